// File: doc/BRIEF.md
# USB Endpoint Halt Arbiter

This block decides, for each endpoint of a USB function controller, whether a host transaction is answered with a STALL handshake or accepted. Each endpoint has two bits of state. The first is a request bit that software writes through a small register port. The second is a sticky halt bit that only hardware can set and only a host Clear Feature (ENDPOINT_HALT) can clear. Only the halt bit decides the handshake. The request bit has an effect only when a transaction arrives: it then arms the halt bit.

The surrounding packet engine pulses `txn_vld` with the endpoint number of each token it receives. One cycle later it gets exactly one of `dec_stall` or `dec_accept`. The same engine reports protocol violations on `viol_vld` and decoded Clear Feature requests on `clrf_vld`. Software sets and clears request bits at address 0 and reads the halt bits at address 1. Because software cannot clear a halt bit, ending a stall takes two steps: software drops its request, then the host clears the halt.

Top module: `usb_ep_halt_ctrl`

## Requirements
- R1: A synchronous active-high `rst` clears every halt bit and every request bit. While `rst` is high and in the cycle after it, both decision outputs are low.
- R2: A write with `reg_addr`=0 loads `reg_wdata[3:0]` into the request bits (bit n belongs to endpoint n). Reading address 0 returns them in bits 3:0, and bits 7:4 read as 0. Writes to any other address change nothing. Address 1 reads the halt bits in bits 3:0. Any other address reads 0. `reg_rdata` is combinational from `reg_addr`.
- R3: No register write sets or clears a halt bit. The halt bits appear on `halt_status` and at address 1, and both views change only through transactions, violations, Clear Feature or reset.
- R4: A transaction for an endpoint whose halt bit is set gives a `dec_stall` pulse in the next cycle.
- R5: A transaction for an endpoint whose halt bit is clear and whose request bit is set gives a `dec_stall` pulse in the next cycle. That halt bit is set from the next cycle on.
- R6: A transaction for an endpoint whose halt bit and request bit are both clear gives a `dec_accept` pulse in the next cycle, and the halt bit stays clear.
- R7: A set halt bit stays set, even after its request bit is cleared, until a Clear Feature for that endpoint arrives.
- R8: A Clear Feature clears the endpoint's halt bit from the next cycle on. If the request bit is still set, the next transaction on that endpoint sets the bit again and is stalled.
- R9: A protocol violation on an endpoint sets its halt bit from the next cycle, whatever the request bit holds. It also wins over a Clear Feature for that endpoint in the same cycle.
- R10: Each transaction for endpoints 0..3 gives exactly one of `dec_stall`/`dec_accept`, never both. A transaction, violation or Clear Feature that names endpoint 4..15 has no effect, and no decision pulse follows it.
- R11: When a Clear Feature and a transaction for the same endpoint arrive in the same cycle, the clear is applied first. The decision then depends only on the request bit, and the halt bit ends set only if the request bit was set.
- R12: A transaction uses the request bits held before a register write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| txn_vld | input | 1 | Host transaction arrival strobe |
| txn_ep | input | 4 | Endpoint number of the transaction |
| viol_vld | input | 1 | Protocol violation strobe |
| viol_ep | input | 4 | Endpoint number of the violation |
| clrf_vld | input | 1 | Host Clear Feature (ENDPOINT_HALT) strobe |
| clrf_ep | input | 4 | Endpoint number of the Clear Feature |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| dec_stall | output | 1 | One-cycle pulse: transaction answered with STALL |
| dec_accept | output | 1 | One-cycle pulse: transaction accepted |
| halt_status | output | 4 | Current halt bits, bit n for endpoint n |

## Verification
The bench targets three kinds of mistake. The first is a request bit cleared after the halt has latched: a design that ties the handshake to the request bit alone would start accepting at that point. The second is a Clear Feature issued while the request is still set: a design that forgets to re-arm would accept the next transaction instead of stalling it. The third is a set of same-cycle collisions: clear with transaction, clear with violation, and register write with transaction. Each collision has only one correct ordering, and a wrong priority shows up as the opposite handshake or a wrong halt bit. Out-of-range endpoint numbers and writes to the halt address are also driven, because a design that truncates the endpoint number would alias them onto endpoints 0..3.

// File: rtl/usb_halt_pkg.sv
package usb_halt_pkg;
  localparam int EPN_W     = 4;  // width of a USB endpoint number
  localparam int ADDR_REQ  = 0;  // software request register
  localparam int ADDR_HALT = 1;  // read-only halt status

  typedef struct packed {
    logic             vld;
    logic [EPN_W-1:0] ep;
  } ep_evt_t;
endpackage

// File: rtl/ep_evt_decode.sv
module ep_evt_decode
  import usb_halt_pkg::*;
#(
  parameter int NUM_EP = 4
) (
  input  ep_evt_t           evt,
  output logic [NUM_EP-1:0] mask
);
  // One-hot endpoint mask; numbers at or above NUM_EP give an empty mask.
  for (genvar i = 0; i < NUM_EP; i++) begin : g_dec
    assign mask[i] = evt.vld && (evt.ep == EPN_W'(i));
  end
endmodule

// File: rtl/halt_req_regs.sv
module halt_req_regs
  import usb_halt_pkg::*;
#(
  parameter int NUM_EP = 4,
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [NUM_EP-1:0] req
);
  logic req_wr_hit;
  assign req_wr_hit = wr_en && (addr == ADDR_W'(ADDR_REQ));

  always_ff @(posedge clk) begin
    if (rst)             req <= '0;
    else if (req_wr_hit) req <= wdata[NUM_EP-1:0];
  end

  a_r2_req_load: assert property (@(posedge clk) disable iff (rst)
    req_wr_hit |=> (req == $past(wdata[NUM_EP-1:0])));
  a_r2_req_hold: assert property (@(posedge clk) disable iff (rst)
    !req_wr_hit |=> $stable(req));
endmodule

// File: rtl/halt_bits.sv
module halt_bits #(
  parameter int NUM_EP = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_EP-1:0] txn_m,
  input  logic [NUM_EP-1:0] viol_m,
  input  logic [NUM_EP-1:0] clr_m,
  input  logic [NUM_EP-1:0] req,
  output logic [NUM_EP-1:0] halt
);
  logic [NUM_EP-1:0] arm_set;  // transaction meets an armed request
  logic [NUM_EP-1:0] any_set;
  logic [NUM_EP-1:0] halt_nxt;

  for (genvar i = 0; i < NUM_EP; i++) begin : g_bit
    assign arm_set[i]  = txn_m[i] && req[i];
    assign any_set[i]  = arm_set[i] || viol_m[i];
    // Clear Feature is applied first; a same-cycle set wins afterwards.
    assign halt_nxt[i] = any_set[i] ? 1'b1 : (clr_m[i] ? 1'b0 : halt[i]);

    always_ff @(posedge clk) begin
      if (rst) halt[i] <= 1'b0;
      else     halt[i] <= halt_nxt[i];
    end

    a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
      (halt[i] && !clr_m[i]) |=> halt[i]);
    a_r9_viol_sets: assert property (@(posedge clk) disable iff (rst)
      viol_m[i] |=> halt[i]);
    a_r5_arm_sets: assert property (@(posedge clk) disable iff (rst)
      (txn_m[i] && req[i]) |=> halt[i]);
    a_r6_no_spurious_set: assert property (@(posedge clk) disable iff (rst)
      (!halt[i] && !txn_m[i] && !viol_m[i]) |=> !halt[i]);
    a_r8_clear_works: assert property (@(posedge clk) disable iff (rst)
      (clr_m[i] && !viol_m[i] && !txn_m[i]) |=> !halt[i]);
  end
endmodule

// File: rtl/stall_decision.sv
module stall_decision #(
  parameter int NUM_EP = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_EP-1:0] txn_m,
  input  logic [NUM_EP-1:0] clr_m,
  input  logic [NUM_EP-1:0] halt,
  input  logic [NUM_EP-1:0] req,
  output logic              stall,
  output logic              accept
);
  // Halt as seen after a same-cycle Clear Feature.
  logic [NUM_EP-1:0] halt_eff;
  logic [NUM_EP-1:0] stall_hit;
  logic              txn_any;
  logic              stall_now;

  assign halt_eff  = halt & ~clr_m;
  assign stall_hit = txn_m & (halt_eff | req);
  assign txn_any   = |txn_m;
  assign stall_now = |stall_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      stall  <= 1'b0;
      accept <= 1'b0;
    end else begin
      stall  <= stall_now;
      accept <= txn_any && !stall_now;
    end
  end

  a_r10_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(stall && accept));
  a_r10_one_each: assert property (@(posedge clk) disable iff (rst)
    txn_any |=> (stall || accept));
  a_r10_none_idle: assert property (@(posedge clk) disable iff (rst)
    !txn_any |=> (!stall && !accept));
  a_r4_halted_stalls: assert property (@(posedge clk) disable iff (rst)
    (|(txn_m & halt & ~clr_m)) |=> stall);
endmodule

// File: rtl/usb_ep_halt_ctrl.sv
module usb_ep_halt_ctrl
  import usb_halt_pkg::*;
#(
  parameter int NUM_EP = 4,
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              txn_vld,
  input  logic [3:0]        txn_ep,
  input  logic              viol_vld,
  input  logic [3:0]        viol_ep,
  input  logic              clrf_vld,
  input  logic [3:0]        clrf_ep,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              dec_stall,
  output logic              dec_accept,
  output logic [NUM_EP-1:0] halt_status
);
  ep_evt_t           txn_e, viol_e, clr_e;
  logic [NUM_EP-1:0] txn_m, viol_m, clr_m;
  logic [NUM_EP-1:0] req;
  logic [NUM_EP-1:0] halt;

  assign txn_e  = '{vld: txn_vld,  ep: txn_ep};
  assign viol_e = '{vld: viol_vld, ep: viol_ep};
  assign clr_e  = '{vld: clrf_vld, ep: clrf_ep};

  ep_evt_decode #(.NUM_EP(NUM_EP)) u_dec_txn  (.evt(txn_e),  .mask(txn_m));
  ep_evt_decode #(.NUM_EP(NUM_EP)) u_dec_viol (.evt(viol_e), .mask(viol_m));
  ep_evt_decode #(.NUM_EP(NUM_EP)) u_dec_clr  (.evt(clr_e),  .mask(clr_m));

  halt_req_regs #(.NUM_EP(NUM_EP), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_req (
    .clk(clk), .rst(rst), .wr_en(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .req(req));

  halt_bits #(.NUM_EP(NUM_EP)) u_halt (
    .clk(clk), .rst(rst), .txn_m(txn_m), .viol_m(viol_m),
    .clr_m(clr_m), .req(req), .halt(halt));

  stall_decision #(.NUM_EP(NUM_EP)) u_dec (
    .clk(clk), .rst(rst), .txn_m(txn_m), .clr_m(clr_m),
    .halt(halt), .req(req), .stall(dec_stall), .accept(dec_accept));

  assign halt_status = halt;

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_W'(ADDR_REQ))       reg_rdata[NUM_EP-1:0] = req;
    else if (reg_addr == ADDR_W'(ADDR_HALT)) reg_rdata[NUM_EP-1:0] = halt;
  end

  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (halt_status == '0 && !dec_stall && !dec_accept));
  a_r3_write_no_halt: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && !txn_vld && !viol_vld && !clrf_vld) |=> $stable(halt_status));
  a_r10_out_of_range: assert property (@(posedge clk) disable iff (rst)
    (txn_vld && txn_m == '0) |=> (!dec_stall && !dec_accept));
endmodule

// File: tb/usb_ep_halt_ctrl_tb.sv
module usb_ep_halt_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst;
  logic       txn_vld, viol_vld, clrf_vld, reg_wr;
  logic [3:0] txn_ep, viol_ep, clrf_ep;
  logic [1:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic       dec_stall, dec_accept;
  logic [3:0] halt_status;

  always #10 clk = ~clk;  // 50 MHz

  usb_ep_halt_ctrl dut_i (
    .clk(clk), .rst(rst), .txn_vld(txn_vld), .txn_ep(txn_ep),
    .viol_vld(viol_vld), .viol_ep(viol_ep), .clrf_vld(clrf_vld),
    .clrf_ep(clrf_ep), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dec_stall(dec_stall),
    .dec_accept(dec_accept), .halt_status(halt_status));

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  bit done     = 0;

  // Reference model state, one entry per endpoint.
  bit m_halt [4];
  bit m_req  [4];
  bit m_stall, m_accept;

  always @(posedge clk) cycles <= cycles + 1;

  task automatic chk(string tag, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int halt_vec();
    int v = 0;
    for (int i = 0; i < 4; i++) if (m_halt[i]) v += (1 << i);
    return v;
  endfunction

  function automatic int req_vec();
    int v = 0;
    for (int i = 0; i < 4; i++) if (m_req[i]) v += (1 << i);
    return v;
  endfunction

  task automatic idle_inputs();
    txn_vld = 0; viol_vld = 0; clrf_vld = 0; reg_wr = 0;
    txn_ep = 0; viol_ep = 0; clrf_ep = 0; reg_addr = 0; reg_wdata = 0;
  endtask

  // Drive one cycle of stimulus at a falling edge, advance the model,
  // then compare after the next falling edge.
  task automatic step(string tag, bit tv, int te, bit vv, int ve,
                      bit cv, int ce, bit wv, int wa, int wd);
    bit nh [4];
    txn_vld = tv; txn_ep = 4'(te);
    viol_vld = vv; viol_ep = 4'(ve);
    clrf_vld = cv; clrf_ep = 4'(ce);
    reg_wr = wv; reg_addr = 2'(wa); reg_wdata = 8'(wd);
    m_stall = 0; m_accept = 0;
    if (tv && te < 4) begin
      // clear first, then the decision
      if ((m_halt[te] && !(cv && ce == te)) || m_req[te]) m_stall = 1;
      else m_accept = 1;
    end
    for (int i = 0; i < 4; i++) begin
      nh[i] = m_halt[i];
      if (cv && ce == i) nh[i] = 0;
      if (tv && te == i && m_req[i]) nh[i] = 1;
      if (vv && ve == i) nh[i] = 1;
    end
    for (int i = 0; i < 4; i++) m_halt[i] = nh[i];
    if (wv && wa == 0)
      for (int i = 0; i < 4; i++) m_req[i] = wd[i];
    @(negedge clk);
    chk(tag, "dec_stall", dec_stall, m_stall);
    chk(tag, "dec_accept", dec_accept, m_accept);
    chk(tag, "halt_status", halt_status, halt_vec());
    idle_inputs();
  endtask

  task automatic rd(string tag, int a);
    int exp;
    idle_inputs();
    reg_addr = 2'(a);
    #1;
    exp = (a == 0) ? req_vec() : ((a == 1) ? halt_vec() : 0);
    chk(tag, "reg_rdata", reg_rdata, exp);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  endtask

  initial begin : watchdog
    wait (cycles > 150000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      finish_run();
    end
  end

  initial begin
    idle_inputs();
    rst = 1;
    for (int i = 0; i < 4; i++) begin m_halt[i] = 0; m_req[i] = 0; end
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "halt_status", halt_status, 0);
    chk("R1", "dec_stall", dec_stall, 0);
    chk("R1", "dec_accept", dec_accept, 0);
    rst = 0;
    rd("R1", 0);
    rd("R1", 1);

    // R2: request register write, upper bits dropped, other addresses ignored
    step("R2", 0,0, 0,0, 0,0, 1,0,'hF5);
    rd("R2", 0);
    step("R2", 0,0, 0,0, 0,0, 1,2,'h0A);
    rd("R2", 0);
    rd("R2", 2);
    // R3: writing the halt address touches nothing
    step("R3", 0,0, 0,0, 0,0, 1,1,'h0F);
    rd("R3", 1);

    // R6: ep1 clear request -> accept
    step("R6", 1,1, 0,0, 0,0, 0,0,0);
    step("R6", 0,0, 0,0, 0,0, 0,0,0);
    // R5: ep0 request set -> stall and halt latched
    step("R5", 1,0, 0,0, 0,0, 0,0,0);
    step("R5", 0,0, 0,0, 0,0, 0,0,0);
    rd("R5", 1);
    // R7: drop request, halt remains, still stalls
    step("R7", 0,0, 0,0, 0,0, 1,0,'h00);
    step("R4", 1,0, 0,0, 0,0, 0,0,0);
    step("R7", 0,0, 0,0, 0,0, 0,0,0);
    // R8: clear feature ends it once request is down
    step("R8", 0,0, 0,0, 1,0, 0,0,0);
    step("R8", 1,0, 0,0, 0,0, 0,0,0);
    step("R8", 0,0, 0,0, 0,0, 0,0,0);
    // R8: clear with request still set -> re-armed on next transaction
    step("R8", 0,0, 0,0, 0,0, 1,0,'h04);
    step("R8", 1,2, 0,0, 0,0, 0,0,0);
    step("R8", 0,0, 0,0, 1,2, 0,0,0);
    step("R8", 1,2, 0,0, 0,0, 0,0,0);
    step("R8", 0,0, 0,0, 0,0, 0,0,0);
    // R11: same-cycle clear and transaction
    step("R11", 1,2, 0,0, 1,2, 0,0,0);
    step("R11", 0,0, 0,0, 0,0, 1,0,'h00);
    step("R11", 1,2, 0,0, 1,2, 0,0,0);
    step("R11", 0,0, 0,0, 0,0, 0,0,0);
    // R9: violation sets halt without a request
    step("R9", 0,0, 1,3, 0,0, 0,0,0);
    step("R9", 1,3, 0,0, 0,0, 0,0,0);
    step("R9", 0,0, 1,1, 1,1, 0,0,0);
    step("R9", 1,1, 0,0, 0,0, 0,0,0);
    // R12: write with same-cycle transaction uses old request value
    step("R12", 0,0, 0,0, 1,1, 0,0,0);
    step("R12", 1,1, 0,0, 0,0, 1,0,'h02);
    step("R12", 1,1, 0,0, 0,0, 1,0,'h00);
    step("R12", 0,0, 0,0, 1,1, 0,0,0);
    // R10: out-of-range endpoints do nothing
    step("R10", 1,7, 1,9, 1,3, 0,0,0);
    step("R10", 1,4, 0,0, 0,0, 0,0,0);
    step("R10", 0,0, 1,12, 0,0, 0,0,0);

    // R10: mixed random traffic checked against the model every cycle
    for (int k = 0; k < 3000; k++) begin
      int r = $urandom;
      step("R10", r[0], int'(r[5:2]) & (r[6] ? 15 : 3),
           r[7] & r[8], int'(r[10:9]),
           r[11] & r[12], int'(r[14:13]),
           r[15] & r[16], int'(r[18:17]), int'(r[26:19]));
      if (r[27]) rd("R2", int'(r[29:28]));
    end

    done = 1;
    finish_run();
  end
endmodule